// File: doc/BRIEF.md
# Two-Wire Bus Control and Status Unit

This block holds the software-visible control state of a two-wire (I2C-style) bus controller and sits between a CPU register port and the bus engine that shifts bits. The engine reports each bus event as a one-cycle pulse with a 5-bit event code. When an event arrives, the block raises an interrupt flag. It then presents the event code on its status output and holds the bus clock line low until software has dealt with the event.

Software writes the control register to clear the flag, to enable the unit and to request start, stop or acknowledge. Clearing the flag releases the clock hold and sends a one-cycle continue strobe to the engine. Software writes the data register to pass a byte to the engine. Such a write is accepted only while the flag is set. A write made at any other time is dropped, and a collision bit is set.

Top module: `twb_ctrl`

## Requirements
- R1: After reset, `ctrl_q` is 0x00, `stat_q` is 0xF8, `data_q` is 0x00, and `scl_hold`, `irq` and `go` are 0.
- R2: A control write (`reg_wr`=1, `reg_sel`=0) loads these bits of `wr_data` into `ctrl_q` at the same positions: bit 6 acknowledge enable, bit 5 start request, bit 4 stop request, bit 2 unit enable and bit 0 interrupt enable. Bit 1 always reads 0. Bit 3 is the collision bit and is not written by a control write.
- R3: An `ev_valid` pulse makes `ctrl_q[7]` (the flag) read 1 in the cycle after the pulse, provided the unit is enabled after that cycle's control write. An event that arrives while the unit is disabled is ignored.
- R4: `stat_q` reads {code, 3'b000} when the flag was 1 in the previous cycle. Here code is the `ev_code` of the latest accepted event. `stat_q` reads 0xF8 when the flag was 0 in the previous cycle.
- R5: `scl_hold` equals the flag in every cycle.
- R6: A control write with bit 7 set clears the flag in the next cycle. In that same cycle `go` is 1 for exactly one cycle. A control write with bit 7 clear leaves the flag unchanged.
- R7: When an accepted event and a flag-clearing write arrive in the same cycle, the flag stays set and `go` stays 0.
- R8: A data write (`reg_wr`=1, `reg_sel`=1) made while the flag is 0 sets `ctrl_q[3]` and leaves `data_q` unchanged.
- R9: A data write made while the flag is 1 loads `data_q` from `wr_data` and clears `ctrl_q[3]`.
- R10: `irq` is 1 exactly when the flag, `ctrl_q[0]` and the input `gie` are all 1.
- R11: A control write that clears bit 2 forces the flag to 0 in the next cycle. This releases `scl_hold`, gives no `go` pulse and returns `stat_q` to 0xF8 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 data |
| wr_data | input | 8 | Write data |
| ev_valid | input | 1 | Bus event pulse from the engine |
| ev_code | input | 5 | Event code, shown in status bits 7..3 |
| gie | input | 1 | Global interrupt enable |
| ctrl_q | output | 8 | Control register readback |
| stat_q | output | 8 | Status register |
| data_q | output | 8 | Data register toward the engine |
| scl_hold | output | 1 | Hold the bus clock line low |
| irq | output | 1 | Interrupt request |
| go | output | 1 | One-cycle continue strobe to the engine |

## Verification
The bench targets the cycle where an event and a flag-clearing write coincide. A design that lets the write win would drop the event and release the clock while work is still pending. It also drives data writes on both sides of the flag edge. A design that samples the flag a cycle late would either accept a collided byte or flag a legal one. Disabling the unit while the flag is set checks that the hold is released without a spurious continue strobe. Every status transition is checked at its exact cycle, so a status register that tracks the flag with no lag, or with too much lag, shows up straight away.

// File: rtl/twb_pkg.sv
package twb_pkg;
  localparam int B_FLAG = 7;
  localparam int B_ACK  = 6;
  localparam int B_STA  = 5;
  localparam int B_STO  = 4;
  localparam int B_WCOL = 3;
  localparam int B_EN   = 2;
  localparam int B_IE   = 0;
endpackage

// File: rtl/twb_ctrl_reg.sv
module twb_ctrl_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cwr,
  input  logic [DW-1:0] wdata,
  input  logic          ev_valid,
  output logic          ev_take,
  output logic          flag_q,
  output logic          ack_q,
  output logic          sta_q,
  output logic          sto_q,
  output logic          en_q,
  output logic          ie_q,
  output logic          go_q
);
  import twb_pkg::*;

  logic en_n, clr;

  always_comb begin
    en_n    = cwr ? wdata[B_EN] : en_q;
    clr     = cwr & wdata[B_FLAG];
    ev_take = ev_valid & en_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
      sta_q  <= 1'b0;
      sto_q  <= 1'b0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      flag_q <= en_n & (ev_take | (flag_q & ~clr));
      go_q   <= flag_q & clr & ~ev_take & en_n;
      en_q   <= en_n;
      if (cwr) begin
        ack_q <= wdata[B_ACK];
        sta_q <= wdata[B_STA];
        sto_q <= wdata[B_STO];
        ie_q  <= wdata[B_IE];
      end
    end
  end

  // R3: an accepted event sets the flag on the next cycle
  p_event_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    ev_take |=> flag_q);
  // R6: the continue strobe only follows a flag that has just fallen
  p_go_after_flag_r6: assert property (@(posedge clk) disable iff (rst)
    go_q |-> (!flag_q && $past(flag_q)));
  // R11: a disabled unit never holds the flag
  p_disabled_no_flag_r11: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !flag_q);
endmodule

// File: rtl/twb_status.sv
module twb_status #(
  parameter int       DW     = 8,
  parameter int       CW     = 5,
  parameter bit [7:0] IDLE_C = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_take,
  input  logic [CW-1:0] ev_code,
  input  logic          flag_i,
  output logic [DW-1:0] stat_q
);
  localparam int LW = DW - CW;

  logic [CW-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      stat_q <= DW'(IDLE_C);
    end else begin
      if (ev_take) code_q <= ev_code;
      stat_q <= flag_i ? {code_q, {LW{1'b0}}} : DW'(IDLE_C);
    end
  end

  // R4: idle code whenever the flag was clear one cycle earlier
  p_idle_when_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(flag_i) |-> stat_q == DW'(IDLE_C));
  // R4: low status bits are zero while a real code is shown
  p_low_bits_zero_r4: assert property (@(posedge clk) disable iff (rst)
    $past(flag_i) |-> stat_q[LW-1:0] == '0);
endmodule

// File: rtl/twb_data.sv
module twb_data #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dwr,
  input  logic [DW-1:0] wdata,
  input  logic          flag_i,
  output logic [DW-1:0] data_q,
  output logic          wc_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      wc_q   <= 1'b0;
    end else if (dwr) begin
      if (flag_i) begin
        data_q <= wdata;
        wc_q   <= 1'b0;
      end else begin
        wc_q   <= 1'b1;
      end
    end
  end

  // R8: a write outside the flag window collides and is dropped
  p_collision_r8: assert property (@(posedge clk) disable iff (rst)
    (dwr && !flag_i) |=> (wc_q && $stable(data_q)));
  // R9: a write inside the flag window is taken
  p_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (dwr && flag_i) |=> (!wc_q && data_q == $past(wdata)));
endmodule

// File: rtl/twb_ctrl.sv
module twb_ctrl #(
  parameter int       DW     = 8,
  parameter int       CW     = 5,
  parameter bit [7:0] IDLE_C = 8'hF8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_valid,
  input  logic [CW-1:0] ev_code,
  input  logic          gie,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] data_q,
  output logic          scl_hold,
  output logic          irq,
  output logic          go
);
  import twb_pkg::*;

  logic cwr, dwr, ev_take;
  logic flag, ack, sta, sto, en, ie, wc;

  assign cwr = reg_wr & ~reg_sel;
  assign dwr = reg_wr & reg_sel;

  twb_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .cwr(cwr), .wdata(wr_data), .ev_valid(ev_valid),
    .ev_take(ev_take), .flag_q(flag), .ack_q(ack), .sta_q(sta), .sto_q(sto),
    .en_q(en), .ie_q(ie), .go_q(go)
  );

  twb_status #(.DW(DW), .CW(CW), .IDLE_C(IDLE_C)) u_stat (
    .clk(clk), .rst(rst), .ev_take(ev_take), .ev_code(ev_code),
    .flag_i(flag), .stat_q(stat_q)
  );

  twb_data #(.DW(DW)) u_data (
    .clk(clk), .rst(rst), .dwr(dwr), .wdata(wr_data), .flag_i(flag),
    .data_q(data_q), .wc_q(wc)
  );

  always_comb begin
    ctrl_q         = '0;
    ctrl_q[B_FLAG] = flag;
    ctrl_q[B_ACK]  = ack;
    ctrl_q[B_STA]  = sta;
    ctrl_q[B_STO]  = sto;
    ctrl_q[B_WCOL] = wc;
    ctrl_q[B_EN]   = en;
    ctrl_q[B_IE]   = ie;
    scl_hold       = flag;
    irq            = flag & ie & gie;
  end

  // R5: the clock hold follows the flag
  p_hold_follows_flag_r5: assert property (@(posedge clk) disable iff (rst)
    scl_hold == ctrl_q[B_FLAG]);
endmodule

// File: tb/test_twb_ctrl.sv
module test_twb_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_sel = 0, ev_valid = 0, gie = 0;
  logic [7:0] wr_data = 0;
  logic [4:0] ev_code = 0;
  logic [7:0] ctrl_q, stat_q, data_q;
  logic scl_hold, irq, go;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  bit m_flag, m_ack, m_sta, m_sto, m_wc, m_en, m_ie, m_go;
  bit [4:0] m_code;
  bit [7:0] m_stat, m_data;

  always #4 clk = ~clk;

  twb_ctrl i_twb_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .wr_data(wr_data),
    .ev_valid(ev_valid), .ev_code(ev_code), .gie(gie), .ctrl_q(ctrl_q),
    .stat_q(stat_q), .data_q(data_q), .scl_hold(scl_hold), .irq(irq), .go(go)
  );

  function automatic bit [7:0] m_ctrl();
    return {m_flag, m_ack, m_sta, m_sto, m_wc, m_en, 1'b0, m_ie};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 ctrl", ctrl_q, m_ctrl());
    chk("R4 stat", stat_q, m_stat);
    chk("R9 data", data_q, m_data);
    chk("R5 hold", {7'b0, scl_hold}, {7'b0, m_flag});
    chk("R10 irq", {7'b0, irq}, {7'b0, m_flag & m_ie & gie});
    chk("R6 go",   {7'b0, go}, {7'b0, m_go});
  endtask

  // drive one cycle of inputs, advance model, compare at next negedge
  task automatic tick(bit wr, bit sel, bit [7:0] d, bit ev, bit [4:0] code, bit g);
    bit en_n, clr, evt;
    reg_wr = wr; reg_sel = sel; wr_data = d; ev_valid = ev; ev_code = code; gie = g;
    en_n = (wr && !sel) ? d[2] : m_en;
    clr  = wr && !sel && d[7];
    evt  = ev && en_n;
    m_stat = m_flag ? {m_code, 3'b000} : 8'hF8;
    m_go   = m_flag & clr & ~evt & en_n;
    if (wr && sel) begin
      if (m_flag) begin m_data = d; m_wc = 0; end
      else m_wc = 1;
    end
    if (wr && !sel) begin
      m_ack = d[6]; m_sta = d[5]; m_sto = d[4]; m_ie = d[0];
    end
    if (evt) m_code = code;
    m_flag = en_n & (evt | (m_flag & ~clr));
    m_en   = en_n;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset values
    chk("R1 ctrl", ctrl_q, 8'h00);
    chk("R1 stat", stat_q, 8'hF8);
    chk("R1 data", data_q, 8'h00);
    chk("R1 outs", {5'b0, scl_hold, irq, go}, 8'h00);

    // R3: event while disabled is ignored
    tick(0, 0, 8'h00, 1, 5'h03, 1);
    chk("R3 disabled", {7'b0, ctrl_q[7]}, 8'h00);
    // R2: field load, bit 1 and bit 3 not written
    tick(1, 0, 8'h7F, 0, 0, 1);
    chk("R2 fields", ctrl_q, 8'h75);
    // R8: data write with flag clear collides
    tick(1, 1, 8'hA5, 0, 0, 1);
    chk("R8 wcol", {7'b0, ctrl_q[3]}, 8'h01);
    chk("R8 data kept", data_q, 8'h00);
    // R3/R4/R5/R10: event sets flag, status one cycle later
    tick(1, 0, 8'h05, 0, 0, 1);
    tick(0, 0, 8'h00, 1, 5'h0A, 1);
    chk("R3 flag", {7'b0, ctrl_q[7]}, 8'h01);
    chk("R4 lag", stat_q, 8'hF8);
    chk("R10 irq", {7'b0, irq}, 8'h01);
    tick(0, 0, 8'h00, 0, 0, 1);
    chk("R4 code", stat_q, 8'h50);
    // R9: accepted data write clears collision
    tick(1, 1, 8'h3C, 0, 0, 0);
    chk("R9 data", data_q, 8'h3C);
    chk("R9 wcol", {7'b0, ctrl_q[3]}, 8'h00);
    // R6: writing 0 to bit 7 has no effect
    tick(1, 0, 8'h05, 0, 0, 1);
    chk("R6 no clear", {7'b0, ctrl_q[7]}, 8'h01);
    // R7: event wins over clear
    tick(1, 0, 8'h85, 1, 5'h11, 1);
    chk("R7 flag held", {7'b0, ctrl_q[7]}, 8'h01);
    chk("R7 no go", {7'b0, go}, 8'h00);
    // R6: clear releases hold with a go pulse
    tick(1, 0, 8'h85, 0, 0, 1);
    chk("R6 go", {6'b0, go, scl_hold}, 8'h02);
    tick(0, 0, 8'h00, 0, 0, 1);
    chk("R6 go once", {7'b0, go}, 8'h00);
    chk("R4 idle", stat_q, 8'hF8);
    // R11: disable while flag set
    tick(0, 0, 8'h00, 1, 5'h1F, 1);
    tick(1, 0, 8'h01, 0, 0, 1);
    chk("R11 flag", {5'b0, ctrl_q[7], scl_hold, go}, 8'h00);
    tick(0, 0, 8'h00, 0, 0, 1);
    chk("R11 stat", stat_q, 8'hF8);

    // random phase: keep the unit mostly enabled
    for (int i = 0; i < 3000; i++) begin
      bit wr, sel, ev, g;
      bit [7:0] d;
      wr  = ($urandom % 4) == 0;
      sel = $urandom % 2;
      d   = 8'($urandom);
      if (($urandom % 8) != 0) d[2] = 1'b1;
      ev  = ($urandom % 5) == 0;
      g   = ($urandom % 4) != 0;
      tick(wr, sel, d, ev, 5'($urandom), g);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule